// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. It runs the sixteen-state test-port sequencer from a test clock and a mode-select pin, and it holds a 4-bit instruction. It shifts data between the serial data input and output through one of four paths: a one-bit pass-through stage, a fixed 32-bit identification word, or one of two external chains. The external chains are the boundary-cell chain and a user data chain. The boundary cells themselves live outside the block.

The current instruction is decoded into control signals for the boundary cells. These are chain select lines, capture, shift and update strobes, a drive-from-chain mode, a high-impedance mode and an AC test strobe. The AC test strobe supports pulsed and pulse-train testing of AC-coupled links. A fixed opcode map is used. Every code outside the supported set behaves as the pass-through instruction, including all zeros, all ones and the unsupported internal-test code.

Top module: `scan_tap_top`

## Requirements
- R1: The sequencer follows the standard sixteen-state test-port graph, sampling `tms` on each rising `tck`. This includes the pause and exit loops. A low `trst_n` forces the reset state at once, without a clock.
- R2: Five consecutive rising `tck` edges with `tms` high bring the sequencer to the reset state from any state.
- R3: In the reset state the active instruction becomes the identification opcode 4'b0110, and all mode outputs go inactive.
- R4: In the capture-instruction state the instruction shift stage loads 4'b0001, and bit 0 is shifted out first.
- R5: Instruction bits shift in LSB first from `tdi`. The new instruction takes effect only when the update-instruction state is left. Until then the previous decode stays on the outputs.
- R6: Opcode map: 0001 sample, 0010 high-Z, 0011 clamp, 0110 identification, 1000 DC extest, 1001 user chain, 1011 pulse extest, 1100 train extest. Every other code selects the one-bit pass-through path.
- R7: The pass-through path captures 0 and delays `tdi` by exactly one shift.
- R8: The identification path captures {VERSION, 28'h0006351} and shifts it out LSB first.
- R9: `chain_capture`, `chain_shift` and `chain_update` pulse in the capture-, shift- and update-data states, and only under the sample, extest, pulse, train or user instructions. `tdo` then follows `bscan_so` or `udr_so`.
- R10: `sel_bscan` is high for sample, extest, pulse and train. `sel_udr` is high for the user chain. `mode_drive` is high for extest, pulse, train and clamp. `mode_hiz` is high only for high-Z.
- R11: `tdo` and `tdo_oe` change on falling `tck`. `tdo_oe` is high only in the shift-data and shift-instruction states.
- R12: `ac_strobe` is high through Run-Test/Idle under pulse extest. Under train extest it toggles on every falling `tck` in Run-Test/Idle. It is low in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| bscan_so | input | 1 | Serial out of the external boundary chain |
| udr_so | input | 1 | Serial out of the external user chain |
| tdo | output | 1 | Serial data out, changes on falling tck |
| tdo_oe | output | 1 | Output enable for the tdo pad driver |
| chain_capture | output | 1 | Capture strobe for the selected external chain |
| chain_shift | output | 1 | Shift enable for the selected external chain |
| chain_update | output | 1 | Update strobe for the selected external chain |
| sel_bscan | output | 1 | Boundary chain is the selected data path |
| sel_udr | output | 1 | User chain is the selected data path |
| mode_drive | output | 1 | Boundary cells drive pins from their update stage |
| mode_hiz | output | 1 | All boundary outputs forced to high impedance |
| ac_strobe | output | 1 | AC test strobe for pulse and train extest |

## Verification
The bench drives every unlisted opcode, all zeros and all ones among them. A decoder with a missing default would then leave no path selected and shift out garbage instead of a one-cycle delayed copy of `tdi`. It reads the identification word across a pause loop, which exposes a shift stage that moves outside the shift state. It checks that the mode outputs stay frozen while a new instruction is being shifted, which would fail if the instruction were applied straight from the shift stage. It checks that five TMS-high clocks or a mid-scan `trst_n` restore the identification instruction. It also checks that the train strobe alternates on consecutive falling edges while the pulse strobe holds steady. Swapping those two behaviours, or letting either leak outside Run-Test/Idle, would show at the strobe.

// File: rtl/scan_tap_pkg.sv
`timescale 1ns/1ps
package scan_tap_pkg;

  localparam int IR_W = 4;
  localparam int ID_W = 32;
  localparam int VER_W = 4;
  localparam logic [ID_W-VER_W-1:0] ID_BODY = 28'h0006351;

  typedef enum logic [3:0] {
    S_TLR, S_RTI,
    S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_state_t;

  localparam logic [IR_W-1:0] OP_SAMPLE = 4'b0001;
  localparam logic [IR_W-1:0] OP_HIZ    = 4'b0010;
  localparam logic [IR_W-1:0] OP_CLAMP  = 4'b0011;
  localparam logic [IR_W-1:0] OP_IDCODE = 4'b0110;
  localparam logic [IR_W-1:0] OP_EXTEST = 4'b1000;
  localparam logic [IR_W-1:0] OP_USER   = 4'b1001;
  localparam logic [IR_W-1:0] OP_PULSE  = 4'b1011;
  localparam logic [IR_W-1:0] OP_TRAIN  = 4'b1100;
  localparam logic [IR_W-1:0] IR_CAPT   = 4'b0001;

  typedef struct packed {
    logic byp;
    logic idc;
    logic bsc;
    logic udr;
    logic drive;
    logic hiz;
    logic pulse;
    logic train;
  } ir_dec_t;

  function automatic tap_state_t tap_next(tap_state_t s, logic m);
    case (s)
      S_TLR:    return m ? S_TLR    : S_RTI;
      S_RTI:    return m ? S_SEL_DR : S_RTI;
      S_SEL_DR: return m ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: return m ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  return m ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: return m ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: return m ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: return m ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: return m ? S_SEL_DR : S_RTI;
      S_SEL_IR: return m ? S_TLR    : S_CAP_IR;
      S_CAP_IR: return m ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  return m ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: return m ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: return m ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: return m ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: return m ? S_SEL_DR : S_RTI;
      default:  return S_TLR;
    endcase
  endfunction

  function automatic ir_dec_t ir_decode(logic [IR_W-1:0] op);
    ir_dec_t d;
    d = '0;
    case (op)
      OP_SAMPLE: d.bsc = 1'b1;
      OP_HIZ:    begin d.byp = 1'b1; d.hiz = 1'b1; end
      OP_CLAMP:  begin d.byp = 1'b1; d.drive = 1'b1; end
      OP_IDCODE: d.idc = 1'b1;
      OP_EXTEST: begin d.bsc = 1'b1; d.drive = 1'b1; end
      OP_USER:   d.udr = 1'b1;
      OP_PULSE:  begin d.bsc = 1'b1; d.drive = 1'b1; d.pulse = 1'b1; end
      OP_TRAIN:  begin d.bsc = 1'b1; d.drive = 1'b1; d.train = 1'b1; end
      default:   d.byp = 1'b1;
    endcase
    return d;
  endfunction

  function automatic logic [ID_W-1:0] id_word(logic [VER_W-1:0] ver);
    return {ver, ID_BODY};
  endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
`timescale 1ns/1ps
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_t state
);

  localparam int RUN_W = 3;
  localparam logic [RUN_W-1:0] RUN_MAX = 3'd5;

  logic [RUN_W-1:0] tms_run;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= S_TLR;
    else         state <= tap_next(state, tms);
  end

  // consecutive TMS-high edge count, observed by the checker below
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)             tms_run <= '0;
    else if (!tms)           tms_run <= '0;
    else if (tms_run != RUN_MAX) tms_run <= tms_run + 1'b1;
  end

  p_five_high_tlr_r2: assert property (@(posedge tck) disable iff (!trst_n)
    (tms && tms_run >= 3'd4) |=> state == S_TLR);

  p_tlr_exit_r1: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_TLR && !tms) |=> state == S_RTI);

endmodule

// File: rtl/scan_tap_ir.sv
`timescale 1ns/1ps
module scan_tap_ir
  import scan_tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_t      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_so
);

  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr <= '0;
      ir_q  <= OP_IDCODE;
    end else begin
      case (state)
        S_TLR:    ir_q  <= OP_IDCODE;
        S_CAP_IR: ir_sr <= IR_CAPT;
        S_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        S_UPD_IR: ir_q  <= ir_sr;
        default:  ;
      endcase
    end
  end

  assign ir_so = ir_sr[0];

  p_capture_pattern_r4: assert property (@(posedge tck) disable iff (!trst_n)
    state == S_CAP_IR |=> ir_so == 1'b1 && ir_sr[1] == 1'b0);

  p_update_takes_r5: assert property (@(posedge tck) disable iff (!trst_n)
    state == S_UPD_IR |=> ir_q == $past(ir_sr));

  p_hold_outside_r5: assert property (@(posedge tck) disable iff (!trst_n)
    (state != S_UPD_IR && state != S_TLR) |=> $stable(ir_q));

  p_reset_idcode_r3: assert property (@(posedge tck) disable iff (!trst_n)
    state == S_TLR |=> ir_q == OP_IDCODE);

endmodule

// File: rtl/scan_tap_dr.sv
`timescale 1ns/1ps
module scan_tap_dr
  import scan_tap_pkg::*;
#(
  parameter logic [VER_W-1:0] VERSION = 4'hA
)(
  input  logic       tck,
  input  logic       trst_n,
  input  tap_state_t state,
  input  logic       tdi,
  input  ir_dec_t    dec,
  output logic       byp_so,
  output logic       id_so
);

  logic [ID_W-1:0] id_sr;
  logic            byp_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) byp_q <= 1'b0;
    else if (dec.byp && state == S_CAP_DR) byp_q <= 1'b0;
    else if (dec.byp && state == S_SH_DR)  byp_q <= tdi;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) id_sr <= '0;
    else if (dec.idc && state == S_CAP_DR) id_sr <= id_word(VERSION);
    else if (dec.idc && state == S_SH_DR)  id_sr <= {tdi, id_sr[ID_W-1:1]};
  end

  assign byp_so = byp_q;
  assign id_so  = id_sr[0];

  p_byp_zero_r7: assert property (@(posedge tck) disable iff (!trst_n)
    (dec.byp && state == S_CAP_DR) |=> byp_so == 1'b0);

  p_byp_delay_r7: assert property (@(posedge tck) disable iff (!trst_n)
    (dec.byp && state == S_SH_DR) |=> byp_so == $past(tdi));

  p_id_lsb_r8: assert property (@(posedge tck) disable iff (!trst_n)
    (dec.idc && state == S_CAP_DR) |=> id_so == 1'b1);

endmodule

// File: rtl/scan_tap_top.sv
`timescale 1ns/1ps
module scan_tap_top
  import scan_tap_pkg::*;
#(
  parameter logic [3:0] VERSION = 4'hA
)(
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  input  logic bscan_so,
  input  logic udr_so,
  output logic tdo,
  output logic tdo_oe,
  output logic chain_capture,
  output logic chain_shift,
  output logic chain_update,
  output logic sel_bscan,
  output logic sel_udr,
  output logic mode_drive,
  output logic mode_hiz,
  output logic ac_strobe
);

  tap_state_t      state;
  logic [IR_W-1:0] ir_q;
  logic            ir_so;
  logic            byp_so;
  logic            id_so;
  ir_dec_t         dec;
  logic            ext_sel;
  logic            in_shift;
  logic            dr_so;
  logic            tdo_nxt;
  logic            ac_q;

  scan_tap_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(state)
  );

  scan_tap_ir u_ir (
    .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
    .ir_q(ir_q), .ir_so(ir_so)
  );

  assign dec = ir_decode(ir_q);

  scan_tap_dr #(.VERSION(VERSION)) u_dr (
    .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi), .dec(dec),
    .byp_so(byp_so), .id_so(id_so)
  );

  assign ext_sel       = dec.bsc | dec.udr;
  assign chain_capture = ext_sel && state == S_CAP_DR;
  assign chain_shift   = ext_sel && state == S_SH_DR;
  assign chain_update  = ext_sel && state == S_UPD_DR;
  assign sel_bscan     = dec.bsc;
  assign sel_udr       = dec.udr;
  assign mode_drive    = dec.drive;
  assign mode_hiz      = dec.hiz;

  always_comb begin
    dr_so = byp_so;
    if (dec.idc)      dr_so = id_so;
    else if (dec.bsc) dr_so = bscan_so;
    else if (dec.udr) dr_so = udr_so;
  end

  assign in_shift = (state == S_SH_DR) || (state == S_SH_IR);
  assign tdo_nxt  = (state == S_SH_IR) ? ir_so : (state == S_SH_DR) ? dr_so : 1'b0;

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_nxt;
      tdo_oe <= in_shift;
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                           ac_q <= 1'b0;
    else if (state == S_RTI && dec.pulse)  ac_q <= 1'b1;
    else if (state == S_RTI && dec.train)  ac_q <= ~ac_q;
    else                                   ac_q <= 1'b0;
  end

  assign ac_strobe = ac_q;

  p_oe_in_shift_r11: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == S_SH_DR || state == S_SH_IR));

  p_one_path_r6: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot({dec.byp, dec.idc, dec.bsc, dec.udr}));

  p_strobes_excl_r9: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({chain_capture, chain_shift, chain_update}));

  p_ac_only_rti_r12: assert property (@(posedge tck) disable iff (!trst_n)
    ac_strobe |-> (state == S_RTI && (dec.pulse || dec.train)));

  p_hiz_not_drive_r10: assert property (@(posedge tck) disable iff (!trst_n)
    !(mode_hiz && mode_drive));

endmodule

// File: tb/test_scan_tap_top.sv
`timescale 1ns/1ps
module test_scan_tap_top;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic bscan_so = 1'b0;
  logic udr_so = 1'b0;
  logic tdo, tdo_oe, chain_capture, chain_shift, chain_update;
  logic sel_bscan, sel_udr, mode_drive, mode_hiz, ac_strobe;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  localparam logic [31:0] EXP_ID = 32'hA0006351;

  always #4 tck = ~tck;

  scan_tap_top i_scan_tap_top (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .bscan_so(bscan_so), .udr_so(udr_so), .tdo(tdo), .tdo_oe(tdo_oe),
    .chain_capture(chain_capture), .chain_shift(chain_shift),
    .chain_update(chain_update), .sel_bscan(sel_bscan), .sel_udr(sel_udr),
    .mode_drive(mode_drive), .mode_hiz(mode_hiz), .ac_strobe(ac_strobe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic do_reset();
    trst_n = 1'b0;
    tms = 1'b1;
    #13;
    trst_n = 1'b1;
    @(negedge tck);
    #1;
  endtask

  // from Run-Test/Idle, back to Run-Test/Idle
  task automatic ir_scan(input logic [3:0] v, output logic [3:0] o);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) begin
      o[i] = tdo;
      tick(i == 3, v[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic dr_scan(input int n, input logic [31:0] v, output logic [31:0] o);
    o = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      o[i] = tdo;
      tick(i == n - 1, v[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  // expected {sel_bscan, sel_udr, mode_drive, mode_hiz}
  function automatic logic [3:0] exp_modes(input logic [3:0] op);
    logic [3:0] r;
    r = 4'b0000;
    if (op == 4'h1 || op == 4'h8 || op == 4'hB || op == 4'hC) r[3] = 1'b1;
    if (op == 4'h9) r[2] = 1'b1;
    if (op == 4'h3 || op == 4'h8 || op == 4'hB || op == 4'hC) r[1] = 1'b1;
    if (op == 4'h2) r[0] = 1'b1;
    return r;
  endfunction

  task automatic t_reset();
    logic [31:0] o;
    do_reset();
    check("R11 oe after reset", {31'b0, tdo_oe}, 32'd0);
    check("R3 modes after reset", {28'b0, sel_bscan, sel_udr, mode_drive, mode_hiz}, 32'd0);
    check("R3 ac after reset", {31'b0, ac_strobe}, 32'd0);
    tick(0, 0);
    dr_scan(32, 32'h0, o);
    check("R8 R3 id word after reset", o, EXP_ID);
  endtask

  task automatic t_ir_capture();
    logic [3:0] o;
    ir_scan(4'b0000, o);
    check("R4 capture pattern", {28'b0, o}, 32'h1);
    ir_scan(4'b0110, o);
    check("R4 capture pattern second", {28'b0, o}, 32'h1);
  endtask

  task automatic t_bypass_codes();
    logic [3:0] codes [8] = '{4'h0, 4'hF, 4'h4, 4'h5, 4'h7, 4'hA, 4'hD, 4'hE};
    logic [3:0] io;
    logic [31:0] o;
    foreach (codes[k]) begin
      ir_scan(codes[k], io);
      check("R6 unlisted code modes", {28'b0, sel_bscan, sel_udr, mode_drive, mode_hiz}, 32'd0);
      dr_scan(8, 32'hB5, o);
      check("R7 R6 bypass delay", o, {24'b0, 8'h6A});
    end
  endtask

  task automatic t_modes();
    logic [3:0] ops [7] = '{4'h1, 4'h2, 4'h3, 4'h8, 4'h9, 4'hB, 4'hC};
    logic [3:0] io;
    logic [31:0] o;
    foreach (ops[k]) begin
      ir_scan(ops[k], io);
      check("R10 R6 mode outputs", {28'b0, sel_bscan, sel_udr, mode_drive, mode_hiz},
            {28'b0, exp_modes(ops[k])});
    end
    ir_scan(4'h2, io);
    dr_scan(6, 32'h2D, o);
    check("R6 highz uses bypass", o, 32'h1A);
    ir_scan(4'h3, io);
    dr_scan(6, 32'h13, o);
    check("R6 clamp uses bypass", o, 32'h26);
  endtask

  task automatic t_chains();
    logic [3:0] io;
    logic [31:0] o;
    ir_scan(4'h8, io);
    bscan_so = 1'b1; udr_so = 1'b0;
    tick(1, 0);
    check("R9 no strobe in select", {29'b0, chain_capture, chain_shift, chain_update}, 32'd0);
    tick(0, 0);
    check("R9 capture strobe", {29'b0, chain_capture, chain_shift, chain_update}, 32'h4);
    tick(0, 0);
    check("R9 shift strobe", {29'b0, chain_capture, chain_shift, chain_update}, 32'h2);
    check("R9 tdo from boundary", {30'b0, tdo, tdo_oe}, 32'h3);
    tick(1, 0);
    tick(1, 0);
    check("R9 update strobe", {29'b0, chain_capture, chain_shift, chain_update}, 32'h1);
    tick(0, 0);
    ir_scan(4'h9, io);
    bscan_so = 1'b0; udr_so = 1'b1;
    dr_scan(5, 32'h0, o);
    check("R9 tdo from user chain", o, 32'h1F);
    ir_scan(4'h6, io);
    tick(1, 0); tick(0, 0);
    check("R9 no strobe under idcode", {31'b0, chain_capture}, 32'd0);
    tick(1, 0); tick(1, 0); tick(0, 0);
    bscan_so = 1'b0; udr_so = 1'b0;
  endtask

  task automatic t_ir_hold();
    ir_scan(4'h0, io_dummy);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    check("R11 oe in shift ir", {31'b0, tdo_oe}, 32'd1);
    for (int i = 0; i < 4; i++) begin
      tick(i == 3, (4'h8 >> i) & 1'b1);
      check("R5 modes frozen during shift", {31'b0, mode_drive}, 32'd0);
    end
    check("R11 oe off in exit", {31'b0, tdo_oe}, 32'd0);
    tick(1, 0);
    check("R5 frozen in update", {31'b0, mode_drive}, 32'd0);
    tick(0, 0);
    check("R5 applied after update", {31'b0, mode_drive}, 32'd1);
  endtask

  logic [3:0] io_dummy;

  task automatic t_tms_reset();
    logic [31:0] o;
    ir_scan(4'hB, io_dummy);
    check("R10 pulse drives", {31'b0, mode_drive}, 32'd1);
    for (int i = 0; i < 5; i++) tick(1, 0);
    check("R2 R3 five tms high", {31'b0, mode_drive}, 32'd0);
    tick(0, 0);
    dr_scan(32, 32'h0, o);
    check("R2 id after tms reset", o, EXP_ID);
  endtask

  task automatic t_pause_loop();
    logic [31:0] o;
    o = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 16; i++) begin
      o[i] = tdo;
      tick(i == 15, 0);
    end
    tick(0, 0); tick(0, 0);
    check("R1 oe off in pause", {31'b0, tdo_oe}, 32'd0);
    tick(1, 0); tick(0, 0);
    for (int i = 16; i < 32; i++) begin
      o[i] = tdo;
      tick(i == 31, 0);
    end
    tick(1, 0); tick(0, 0);
    check("R1 R8 id across pause", o, EXP_ID);
  endtask

  task automatic t_ac();
    logic a, b, c;
    ir_scan(4'hB, io_dummy);
    a = ac_strobe; tick(0, 0); b = ac_strobe;
    check("R12 pulse high in idle", {30'b0, a, b}, 32'h3);
    tick(1, 0);
    check("R12 pulse low outside idle", {31'b0, ac_strobe}, 32'd0);
    tick(0, 0); tick(1, 0); tick(1, 0); tick(0, 0);
    ir_scan(4'hC, io_dummy);
    a = ac_strobe; tick(0, 0); b = ac_strobe; tick(0, 0); c = ac_strobe;
    check("R12 train toggles", {29'b0, a ^ b, b ^ c, 1'b0}, 32'h6);
    ir_scan(4'h8, io_dummy);
    tick(0, 0);
    check("R12 quiet under dc extest", {31'b0, ac_strobe}, 32'd0);
  endtask

  task automatic t_async_reset();
    logic [31:0] o;
    ir_scan(4'h8, io_dummy);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    #1 trst_n = 1'b0;
    #1;
    check("R1 async reset oe", {31'b0, tdo_oe}, 32'd0);
    check("R1 R3 async reset modes", {31'b0, mode_drive}, 32'd0);
    @(negedge tck);
    trst_n = 1'b1;
    #1;
    tick(0, 0);
    dr_scan(32, 32'h0, o);
    check("R1 id after async reset", o, EXP_ID);
  endtask

  initial begin
    t_reset();
    t_ir_capture();
    t_bypass_codes();
    t_modes();
    t_chains();
    t_ir_hold();
    t_tms_reset();
    t_pause_loop();
    t_ac();
    t_async_reset();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

endmodule